// File: doc/BRIEF.md
# Branch and Jump Program-Counter Sequencer

This block is the program-counter unit for a stream of fixed 32-bit RISC instructions. It holds the fetch address in a register. On every rising clock edge it loads that register with the address of the next instruction. The next address depends on the instruction word presented for the current address and on two register operand values supplied by the surrounding datapath.

Six kinds of step are handled:
- a plain advance by one word;
- a branch taken when the operands are equal;
- a branch taken when the operands differ;
- an absolute jump to a 26-bit word index;
- a jump that also records a return address;
- a jump through a register operand, used for returns and computed jumps.

For the recording jump, the block raises a one-cycle write request for register 31 and supplies the return address as its data. Instruction memory, the register file and the ALU sit outside the block. The block has no pipeline: the word at `pc` is expected to be present on `instr` during the same cycle.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` loads `RESET_VEC` (default 0x00000000), whatever the instruction. The link write request stays low during any cycle in which `rst` is high.
- R2: A non-control instruction loads `pc + 4` at the next edge. This covers any opcode (bits 31:26) other than 000010, 000011, 000100 and 000101. It also covers opcode 000000 with any function field (bits 5:0) other than 001000.
- R3: Opcode 000100 (branch on equal) with `rs_val == rt_val` loads `pc + 4 + (sext(instr[15:0]) << 2)`.
- R4: Opcode 000100 with `rs_val != rt_val` loads `pc + 4`.
- R5: Opcode 000101 (branch on not equal) with `rs_val != rt_val` loads the branch target from R3. With `rs_val == rt_val` it loads `pc + 4`.
- R6: The branch offset is signed. Offsets with bit 15 set move backwards. The most negative offset, 0x8000, subtracts 0x20000 from `pc + 4`, modulo 2^32.
- R7: Opcode 000010 (jump) loads `{(pc+4)[31:28], instr[25:0], 2'b00}`. The upper four bits come from `pc + 4`, so they change when `pc + 4` crosses a 256 MiB boundary.
- R8: Opcode 000011 (jump and link) loads the same target as R7. In the same cycle it drives `link_we` high, `link_idx` to 31 and `link_data` to `pc + 4`.
- R9: Opcode 000000 with function field 001000 (register jump) loads `rs_val` into `pc`.
- R10: `link_we` is low in every cycle that does not hold a jump-and-link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Instruction word at the current `pc` |
| rs_val | input | 32 | Value of the register named by bits 25:21 |
| rt_val | input | 32 | Value of the register named by bits 20:16 |
| pc | output | 32 | Current fetch address |
| link_we | output | 1 | Return-address register write request |
| link_idx | output | 5 | Register number to write (always 31) |
| link_data | output | 32 | Return address to write |

## Verification
A jump-and-link performs two actions in one cycle: it writes the link register and it moves `pc` to the jump target. The bench places one jump-and-link at 0x0FFFFFFC, where `pc + 4` crosses into the next 256 MiB region. There it checks that the link data and the new region bits both come from the same incremented address.

A second jump-and-link is presented while `rst` is high. The bench expects the reset to win: no write request, and `pc` at the reset vector.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;

    localparam int unsigned XLEN      = 32;
    localparam int unsigned OP_W      = 6;
    localparam int unsigned FN_W      = 6;
    localparam int unsigned REG_W     = 5;
    localparam int unsigned IMM_W     = 16;
    localparam int unsigned JIDX_W    = 26;
    localparam int unsigned WORD_SH   = 2;
    localparam int unsigned REGION_W  = XLEN - JIDX_W - WORD_SH;
    localparam int unsigned STEP      = 4;
    localparam logic [REG_W-1:0] LINK_REG = REG_W'(31);

    localparam logic [OP_W-1:0] OPC_SPECIAL = 6'b000000;
    localparam logic [OP_W-1:0] OPC_JMP     = 6'b000010;
    localparam logic [OP_W-1:0] OPC_JAL     = 6'b000011;
    localparam logic [OP_W-1:0] OPC_BEQ     = 6'b000100;
    localparam logic [OP_W-1:0] OPC_BNE     = 6'b000101;
    localparam logic [FN_W-1:0] FN_JREG     = 6'b001000;

    typedef enum logic [2:0] {
        FLOW_SEQ  = 3'd0,
        FLOW_BEQ  = 3'd1,
        FLOW_BNE  = 3'd2,
        FLOW_JMP  = 3'd3,
        FLOW_JAL  = 3'd4,
        FLOW_JREG = 3'd5
    } flow_e;

    typedef struct packed {
        flow_e              kind;
        logic [REG_W-1:0]   src_a;
        logic [REG_W-1:0]   src_b;
        logic [IMM_W-1:0]   offs;
        logic [JIDX_W-1:0]  jidx;
    } dec_t;

    typedef struct packed {
        logic [XLEN-1:0] seq;
        logic [XLEN-1:0] branch;
        logic [XLEN-1:0] jump;
    } tgt_t;

    function automatic logic [XLEN-1:0] word_offset(input logic [IMM_W-1:0] imm);
        logic [XLEN-1:0] ext;
        ext = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
        return ext << WORD_SH;
    endfunction

    function automatic logic [XLEN-1:0] region_join(input logic [XLEN-1:0] base,
                                                    input logic [JIDX_W-1:0] idx);
        return {base[XLEN-1 -: REGION_W], idx, {WORD_SH{1'b0}}};
    endfunction

endpackage

// File: rtl/pcs_decode.sv
module pcs_decode
    import pc_seq_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output dec_t            dec
);
    logic [OP_W-1:0] opc;
    logic [FN_W-1:0] fn;

    assign opc = instr[XLEN-1 -: OP_W];
    assign fn  = instr[FN_W-1:0];

    always_comb begin
        dec.src_a = instr[XLEN-OP_W-1 -: REG_W];
        dec.src_b = instr[XLEN-OP_W-REG_W-1 -: REG_W];
        dec.offs  = instr[IMM_W-1:0];
        dec.jidx  = instr[JIDX_W-1:0];
        unique case (opc)
            OPC_JMP: dec.kind = FLOW_JMP;
            OPC_JAL: dec.kind = FLOW_JAL;
            OPC_BEQ: dec.kind = FLOW_BEQ;
            OPC_BNE: dec.kind = FLOW_BNE;
            OPC_SPECIAL: dec.kind = (fn == FN_JREG) ? FLOW_JREG : FLOW_SEQ;
            default: dec.kind = FLOW_SEQ;
        endcase
    end
endmodule

// File: rtl/pcs_target.sv
module pcs_target
    import pc_seq_pkg::*;
(
    input  logic [XLEN-1:0] pc_cur,
    input  dec_t            dec,
    output tgt_t            tgt
);
    logic [XLEN-1:0] inc;

    assign inc        = pc_cur + XLEN'(STEP);
    assign tgt.seq    = inc;
    assign tgt.branch = inc + word_offset(dec.offs);
    assign tgt.jump   = region_join(inc, dec.jidx);
endmodule

// File: rtl/pcs_select.sv
module pcs_select
    import pc_seq_pkg::*;
(
    input  flow_e           kind,
    input  tgt_t            tgt,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic [XLEN-1:0] nxt,
    output logic            link_req
);
    logic same;

    assign same = (opa == opb);

    always_comb begin
        nxt      = tgt.seq;
        link_req = 1'b0;
        unique case (kind)
            FLOW_BEQ:  nxt = same ? tgt.branch : tgt.seq;
            FLOW_BNE:  nxt = same ? tgt.seq : tgt.branch;
            FLOW_JMP:  nxt = tgt.jump;
            FLOW_JAL: begin
                nxt      = tgt.jump;
                link_req = 1'b1;
            end
            FLOW_JREG: nxt = opa;
            default:   nxt = tgt.seq;
        endcase
    end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pc_seq_pkg::*;
#(
    parameter logic [31:0] RESET_VEC = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] instr,
    input  logic [31:0] rs_val,
    input  logic [31:0] rt_val,
    output logic [31:0] pc,
    output logic        link_we,
    output logic [4:0]  link_idx,
    output logic [31:0] link_data
);
    dec_t            dec;
    tgt_t            tgt;
    logic [XLEN-1:0] nxt;
    logic            link_req;
    logic [XLEN-1:0] pc_q;

    pcs_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    pcs_target u_tgt (
        .pc_cur (pc_q),
        .dec    (dec),
        .tgt    (tgt)
    );

    pcs_select u_sel (
        .kind     (dec.kind),
        .tgt      (tgt),
        .opa      (rs_val),
        .opb      (rt_val),
        .nxt      (nxt),
        .link_req (link_req)
    );

    always_ff @(posedge clk) begin
        if (rst) pc_q <= RESET_VEC;
        else     pc_q <= nxt;
    end

    assign pc        = pc_q;
    assign link_we   = link_req & ~rst;
    assign link_idx  = LINK_REG;
    assign link_data = tgt.seq;
endmodule

// File: rtl/pc_sequencer_checker.sv
module pc_sequencer_checker (
    input logic        clk,
    input logic        rst,
    input logic [31:0] instr,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic [31:0] pc,
    input logic        link_we,
    input logic [4:0]  link_idx,
    input logic [31:0] link_data
);
    logic [5:0]  op;
    logic [31:0] boff;
    logic        is_jr;
    logic        is_ctl;

    assign op     = instr[31:26];
    assign boff   = {{14{instr[15]}}, instr[15:0], 2'b00};
    assign is_jr  = (op == 6'b000000) && (instr[5:0] == 6'b001000);
    assign is_ctl = is_jr || (op == 6'b000010) || (op == 6'b000011) ||
                    (op == 6'b000100) || (op == 6'b000101);

    p_seq_r2: assert property (@(posedge clk) disable iff (rst)
        !is_ctl |=> pc == $past(pc) + 32'd4);

    p_beq_taken_r3: assert property (@(posedge clk) disable iff (rst)
        (op == 6'b000100 && rs_val == rt_val) |=> pc == $past(pc) + 32'd4 + $past(boff));

    p_beq_fall_r4: assert property (@(posedge clk) disable iff (rst)
        (op == 6'b000100 && rs_val != rt_val) |=> pc == $past(pc) + 32'd4);

    p_bne_taken_r5: assert property (@(posedge clk) disable iff (rst)
        (op == 6'b000101 && rs_val != rt_val) |=> pc == $past(pc) + 32'd4 + $past(boff));

    p_jump_r7: assert property (@(posedge clk) disable iff (rst)
        (op == 6'b000010) |=> pc[27:0] == {$past(instr[25:0]), 2'b00});

    p_jal_link_r8: assert property (@(posedge clk) disable iff (rst)
        (op == 6'b000011) |-> (link_we && link_idx == 5'd31 && link_data == pc + 32'd4));

    p_jreg_r9: assert property (@(posedge clk) disable iff (rst)
        is_jr |=> pc == $past(rs_val));

    p_link_only_jal_r10: assert property (@(posedge clk) disable iff (rst)
        link_we |-> op == 6'b000011);
endmodule

bind pc_sequencer pc_sequencer_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .instr     (instr),
    .rs_val    (rs_val),
    .rt_val    (rt_val),
    .pc        (pc),
    .link_we   (link_we),
    .link_idx  (link_idx),
    .link_data (link_data)
);

// File: tb/pc_sequencer_test.sv
module pc_sequencer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = 32'h0;
    logic [31:0] rs_val = 32'h0;
    logic [31:0] rt_val = 32'h0;
    logic [31:0] pc;
    logic        link_we;
    logic [4:0]  link_idx;
    logic [31:0] link_data;

    always #2.5 clk = ~clk;

    pc_sequencer uut (
        .clk       (clk),
        .rst       (rst),
        .instr     (instr),
        .rs_val    (rs_val),
        .rt_val    (rt_val),
        .pc        (pc),
        .link_we   (link_we),
        .link_idx  (link_idx),
        .link_data (link_data)
    );

    typedef struct {
        logic [31:0] next_pc;
        logic        we;
        logic [31:0] ldata;
        string       req;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          fails  = 0;
    logic [31:0] model_pc = 32'h0;
    bit          done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Driver: applies one instruction and pushes the expected result.
    task automatic drive(input logic [31:0] w, input logic [31:0] a,
                         input logic [31:0] b, input bit r, input string req);
        exp_t e;
        logic [31:0] inc;
        logic [5:0]  o;
        @(negedge clk);
        instr = w; rs_val = a; rt_val = b; rst = r;
        inc = model_pc + 32'd4;
        o = w[31:26];
        e.req = req; e.we = 1'b0; e.ldata = inc; e.next_pc = inc;
        if (o == 6'd2 || o == 6'd3) e.next_pc = {inc[31:28], w[25:0], 2'b00};
        if ((o == 6'd4 && a == b) || (o == 6'd5 && a != b))
            e.next_pc = inc + ({{16{w[15]}}, w[15:0]} << 2);
        if (o == 6'd0 && w[5:0] == 6'd8) e.next_pc = a;
        if (o == 6'd3) e.we = 1'b1;
        if (r) begin
            e.next_pc = 32'h0;
            e.we = 1'b0;
        end
        model_pc = e.next_pc;
        sb.push_back(e);
    endtask

    // Monitor: checks the link outputs mid-cycle and pc after the edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb[0];
                check(link_we == e.we, e.req, "link_we", 32'(link_we), 32'(e.we));
                if (e.we) begin
                    check(link_data == e.ldata, e.req, "link_data", link_data, e.ldata);
                    check(link_idx == 5'd31, e.req, "link_idx", 32'(link_idx), 32'd31);
                end
                @(posedge clk);
                #1;
                check(pc == e.next_pc, e.req, "pc", pc, e.next_pc);
                void'(sb.pop_front());
            end
        end
    end

    function automatic logic [31:0] ityp(input logic [5:0] o, input logic [15:0] imm);
        return {o, 5'd1, 5'd2, imm};
    endfunction

    initial begin
        repeat (2) @(posedge clk);
        #1;
        check(pc == 32'h0, "R1", "pc after reset", pc, 32'h0);
        check(link_we == 1'b0, "R1", "link_we in reset", 32'(link_we), 32'h0);
        drive(32'h0232_4020, 0, 0, 0, "R2");               // funct 0x20 add -> +4
        drive(32'h8C00_0000, 0, 0, 0, "R2");               // opcode 100011 -> +4
        drive(32'h0000_0009, 0, 0, 0, "R2");               // special funct 0x09 -> +4
        drive(ityp(6'd4, 16'h0003), 5, 5, 0, "R3");
        drive(ityp(6'd4, 16'h0003), 5, 6, 0, "R4");
        drive(ityp(6'd5, 16'hFFFE), 1, 2, 0, "R5_R6");     // backward
        drive(ityp(6'd5, 16'h0040), 7, 7, 0, "R5");        // untaken
        drive(ityp(6'd4, 16'h8000), 9, 9, 0, "R6");        // most negative
        drive(32'h03E0_0008, 32'h0FFF_FFF8, 0, 0, "R9");
        drive(32'h0000_0000, 0, 0, 0, "R10");
        drive({6'd3, 26'h000_0040}, 0, 0, 0, "R8");        // jal across region
        drive({6'd2, 26'h3FF_FFFF}, 0, 0, 0, "R7");
        drive(32'h0060_0008, 32'h0000_0400, 0, 0, "R9");
        drive({6'd3, 26'h000_0010}, 0, 0, 1, "R1");        // reset beats jal
        drive({6'd3, 26'h000_0010}, 0, 0, 0, "R8");
        drive(ityp(6'd5, 16'h7FFF), 3, 3, 0, "R10");
        drive({6'd2, 26'h000_0005}, 0, 0, 0, "R7_R10");
        @(negedge clk);
        instr = 32'h0;
        while (sb.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule